// File: doc/BRIEF.md
# Scan Slice Code Decoder

This block turns a compressed stream of short slice-codes from a tester channel into full-width scan slices for a set of parallel internal scan chains. Each code has a two-bit command in its upper bits and a data field in its lower bits. A slice is opened with a fill value, either all zeros or all ones. Further codes then force single target bits to the opposite of that fill, or paste a whole aligned group of bits as given. When the next slice is opened, or when `flush` is asserted, the finished slice is sent to the chains as one parallel word with a one-cycle valid strobe.

Codes arrive on a valid/ready channel. A code is consumed on a rising edge where `code_valid` and `code_ready` are both high. The decoder holds `code_ready` low only in cycles where `flush` is high. A producer that sees `code_ready` low must keep its code and data steady until the code is consumed. The output side has no back-pressure: the chains must take each word in the cycle that `slice_valid` is high.

Top module: `scan_slice_decoder`

## Requirements
- R1: With N chains, the data field is K = ceil(log2(N+1)) bits and a code is K+2 bits. The command is `code_data[K+1:K]` and the data field is `code_data[K-1:0]`. Slice bit i drives chain i.
- R2: Command 00 opens a slice with every bit 0. Command 01 opens a slice with every bit 1. In both cases, the bit indexed by the data field is set to the opposite of the fill.
- R3: Command 10 sets the indexed bit of the open slice to the opposite of that slice's fill. When no slice is open, a command 10 is ignored and does not open one.
- R4: A data field of N or more, used as a bit index by commands 00, 01 or 10, changes no bit.
- R5: Command 11 arrives in pairs. The first code of a pair gives the start index S of a group. The second code's data bit K-1-j is written to slice bit S+j, and writes that would go past bit N-1 are dropped. The last group may therefore be narrower than K bits.
- R6: Consuming a 00 or 01 code while a slice is open makes `slice_valid` high for the next cycle, with `slice_data` equal to the finished slice. If no slice was open, `slice_valid` stays low.
- R7: While `flush` is high, `code_ready` is low and no code is consumed. If a slice is open, `flush` emits it in the next cycle and closes it. If no slice is open, `flush` emits nothing.
- R8: `slice_data` only changes in a cycle in which `slice_valid` is high.
- R9: A first-of-pair 11 code whose index is not a multiple of K, or is N or more, is ignored and sets `err_sticky`. The flag stays high until reset.
- R10: After reset, `slice_valid` and `err_sticky` are low, `code_ready` is high and no slice is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | A slice-code is offered |
| code_ready | output | 1 | The decoder can take a code this cycle |
| code_data | input | K+2 | Slice-code: command in the upper two bits, data field below |
| flush | input | 1 | Emit the open slice and close it |
| slice_valid | output | 1 | One-cycle strobe: `slice_data` holds a finished slice |
| slice_data | output | N | Parallel word for the scan chains, bit i to chain i |
| err_sticky | output | 1 | A bad group index was seen since reset |

## Verification
Every result is due exactly one cycle after the edge that consumes the code or the flush that causes it. A finished slice appears the cycle after the next opening code or flush. An error flag appears the cycle after the bad group index. `code_ready` responds to `flush` within the same cycle, with no clock in between. The bench drives one stimulus per clock and samples the outputs 1 ns after each edge. At each sample it compares `slice_valid`, and `slice_data` whenever an emission is expected, against its own model, so a strobe that comes early, late or not at all counts as a mismatch. Random slices go through an encoder in the bench, and the bench checks that each slice it gets back has the care bits unchanged and every don't-care bit equal to the chosen fill.

// File: rtl/scan_dec_pkg.sv
package scan_dec_pkg;
  typedef enum logic [1:0] {
    CMD_OPEN0 = 2'b00,
    CMD_OPEN1 = 2'b01,
    CMD_FLIP  = 2'b10,
    CMD_GROUP = 2'b11
  } cmd_e;
endpackage

// File: rtl/sd_code_split.sv
module sd_code_split
  import scan_dec_pkg::*;
#(
  parameter int N_CH = 10,
  parameter int KW   = $clog2(N_CH + 1),
  parameter int CW   = KW + 2
) (
  input  logic [CW-1:0] code,
  output cmd_e          cmd,
  output logic [KW-1:0] field,
  output logic          opens,
  output logic          idx_ok,
  output logic          grp_ok
);
  always_comb begin
    cmd    = cmd_e'(code[CW-1:CW-2]);
    field  = code[KW-1:0];
    opens  = ~code[CW-1];
    idx_ok = int'(field) < N_CH;
    grp_ok = idx_ok && ((int'(field) % KW) == 0);
  end
endmodule

// File: rtl/sd_slice_buf.sv
module sd_slice_buf
  import scan_dec_pkg::*;
#(
  parameter int N_CH = 10,
  parameter int KW   = $clog2(N_CH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            flush,
  input  cmd_e            cmd,
  input  logic [KW-1:0]   field,
  input  logic            idx_ok,
  input  logic            grp_ok,
  output logic [N_CH-1:0] buf_q,
  output logic            open_q,
  output logic            err_q,
  output logic            emit
);
  logic [N_CH-1:0] buf_d;
  logic            open_d, err_d, fill_q, fill_d, half_q, half_d;
  logic [KW-1:0]   base_q, base_d;

  always_comb begin
    buf_d  = buf_q;
    open_d = open_q;
    err_d  = err_q;
    fill_d = fill_q;
    half_d = half_q;
    base_d = base_q;
    emit   = 1'b0;
    if (flush) begin
      emit   = open_q;
      open_d = 1'b0;
      half_d = 1'b0;
    end else if (take) begin
      unique case (cmd)
        CMD_OPEN0, CMD_OPEN1: begin
          emit   = open_q;
          fill_d = cmd[0];
          open_d = 1'b1;
          half_d = 1'b0;
          for (int i = 0; i < N_CH; i++)
            buf_d[i] = (idx_ok && int'(field) == i) ? ~cmd[0] : cmd[0];
        end
        CMD_FLIP: begin
          half_d = 1'b0;
          if (open_q)
            for (int i = 0; i < N_CH; i++)
              if (idx_ok && int'(field) == i) buf_d[i] = ~fill_q;
        end
        default: begin
          if (open_q) begin
            if (!half_q) begin
              if (grp_ok) begin
                half_d = 1'b1;
                base_d = field;
              end else begin
                err_d = 1'b1;
              end
            end else begin
              half_d = 1'b0;
              for (int i = 0; i < N_CH; i++)
                if (i >= int'(base_q) && i < int'(base_q) + KW)
                  buf_d[i] = field[KW-1-(i-int'(base_q))];
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
      fill_q <= 1'b0;
      half_q <= 1'b0;
      base_q <= '0;
    end else begin
      buf_q  <= buf_d;
      open_q <= open_d;
      err_q  <= err_d;
      fill_q <= fill_d;
      half_q <= half_d;
      base_q <= base_d;
    end
  end

  a_r4_open_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !flush && (cmd == CMD_OPEN0 || cmd == CMD_OPEN1) && !idx_ok)
      |=> (buf_q == {N_CH{$past(cmd[0])}}));
  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r7_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !open_q);
  a_r3_flip_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && take && !flush && cmd == CMD_FLIP) |=> !open_q);
endmodule

// File: rtl/sd_slice_out.sv
module sd_slice_out #(
  parameter int N_CH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emit,
  input  logic [N_CH-1:0] word,
  output logic            out_valid,
  output logic [N_CH-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_word <= word;
    end
  end

  a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));
endmodule

// File: rtl/scan_slice_decoder.sv
module scan_slice_decoder
  import scan_dec_pkg::*;
#(
  parameter int N_CH = 10,
  parameter int KW   = $clog2(N_CH + 1),
  parameter int CW   = KW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            code_valid,
  output logic            code_ready,
  input  logic [CW-1:0]   code_data,
  input  logic            flush,
  output logic            slice_valid,
  output logic [N_CH-1:0] slice_data,
  output logic            err_sticky
);
  cmd_e            cmd;
  logic [KW-1:0]   field;
  logic            opens, idx_ok, grp_ok, take, emit, open_q;
  logic [N_CH-1:0] buf_q;

  assign code_ready = ~flush;
  assign take       = code_valid & code_ready;

  sd_code_split #(.N_CH(N_CH), .KW(KW), .CW(CW)) split_i (
    .code(code_data), .cmd(cmd), .field(field), .opens(opens),
    .idx_ok(idx_ok), .grp_ok(grp_ok)
  );

  sd_slice_buf #(.N_CH(N_CH), .KW(KW)) buf_i (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush), .cmd(cmd),
    .field(field), .idx_ok(idx_ok), .grp_ok(grp_ok), .buf_q(buf_q),
    .open_q(open_q), .err_q(err_sticky), .emit(emit)
  );

  sd_slice_out #(.N_CH(N_CH)) out_i (
    .clk(clk), .rst_n(rst_n), .emit(emit), .word(buf_q),
    .out_valid(slice_valid), .out_word(slice_data)
  );

  a_r6_emit_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    slice_valid |-> $past(flush || (code_valid && code_ready && opens)));
  a_r7_no_take_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !open_q) |=> !slice_valid);
endmodule

// File: tb/scan_slice_decoder_tb_top.sv
module scan_slice_decoder_tb_top;
  localparam int N  = 10;
  localparam int K  = $clog2(N + 1);
  localparam int C  = K + 2;
  localparam int NG = (N + K - 1) / K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_valid = 1'b0;
  logic [C-1:0] code_data = '0;
  logic flush = 1'b0;
  logic code_ready, slice_valid, err_sticky;
  logic [N-1:0] slice_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit ref_open = 1'b0;
  logic [N-1:0] ref_cur = '0;

  always #2 clk = ~clk;

  scan_slice_decoder #(.N_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
    .code_data(code_data), .flush(flush), .slice_valid(slice_valid),
    .slice_data(slice_data), .err_sticky(err_sticky)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_out(input bit exp_emit, input logic [N-1:0] exp, input string req);
    check(slice_valid == exp_emit, req, 32'(slice_valid), 32'(exp_emit));
    if (exp_emit) check(slice_data == exp, req, 32'(slice_data), 32'(exp));
  endtask

  // one code per clock; result sampled 1 ns after the consuming edge
  task automatic send(input logic [1:0] cc, input int d, input string req);
    bit em;
    logic [N-1:0] snap;
    em   = ref_open && !cc[1];
    snap = ref_cur;
    @(negedge clk);
    code_valid = 1'b1;
    code_data  = {cc, d[K-1:0]};
    @(posedge clk);
    #1;
    code_valid = 1'b0;
    cmp_out(em, snap, req);
  endtask

  task automatic do_flush(input string req);
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    cmp_out(ref_open, ref_cur, req);
    ref_open = 1'b0;
  endtask

  task automatic encode(input logic [N-1:0] val, input logic [N-1:0] care);
    int ones, zeros, first, cnt[NG];
    bit fill;
    logic [N-1:0] full;
    logic [K-1:0] gd;
    ones = 0; zeros = 0;
    for (int i = 0; i < N; i++)
      if (care[i]) begin if (val[i]) ones++; else zeros++; end
    fill = ones > zeros;
    for (int i = 0; i < N; i++) full[i] = care[i] ? val[i] : fill;
    for (int g = 0; g < NG; g++) cnt[g] = 0;
    for (int i = 0; i < N; i++) if (full[i] != fill) cnt[i / K]++;
    first = N;
    for (int i = N - 1; i >= 0; i--)
      if (full[i] != fill && cnt[i / K] <= 2) first = i;
    send({1'b0, fill}, first, "R2 R6 open");
    ref_open = 1'b1;
    ref_cur  = full;
    for (int i = 0; i < N; i++)
      if (full[i] != fill && cnt[i / K] <= 2 && i != first) send(2'b10, i, "R3 flip");
    for (int g = 0; g < NG; g++)
      if (cnt[g] > 2) begin
        gd = '0;
        for (int j = 0; j < K; j++) if (g * K + j < N) gd[K-1-j] = full[g * K + j];
        send(2'b11, g * K, "R5 group index");
        send(2'b11, int'(gd), "R5 group data");
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(slice_valid == 1'b0, "R10 valid", 32'(slice_valid), 0);
    check(err_sticky == 1'b0, "R10 err", 32'(err_sticky), 0);
    check(code_ready == 1'b1, "R10 ready", 32'(code_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: flip with no open slice is ignored; the next open emits nothing
    send(2'b10, 3, "R3 no slice");
    // R5 R1: group pair on the first group
    send(2'b00, 7, "R3 open after stray flip");
    ref_open = 1'b1;
    ref_cur  = '0;
    ref_cur[7] = 1'b1;
    send(2'b11, 0, "R5 index");
    send(2'b11, 4'b1110, "R5 data");
    ref_cur[0] = 1'b1; ref_cur[1] = 1'b1; ref_cur[2] = 1'b1; ref_cur[3] = 1'b0;
    // R6 emits the example slice; R4 out-of-range index keeps all ones
    send(2'b01, N, "R6 R5 emit example");
    ref_cur = '1;
    send(2'b10, 2, "R3 flip to zero");
    ref_cur[2] = 1'b0;
    send(2'b10, 15, "R4 flip none");
    send(2'b00, N, "R4 R3 emit ones slice");
    ref_cur = '0;
    // R5: narrow last group, writes past N-1 dropped
    send(2'b11, 8, "R5 last group index");
    send(2'b11, 4'b1011, "R5 last group data");
    ref_cur[8] = 1'b1;

    for (int s = 0; s < 40; s++) begin
      logic [N-1:0] v, m;
      v = N'($urandom);
      m = N'($urandom) | N'($urandom);
      if (s % 4 == 0) m = N'($urandom) & N'($urandom);
      encode(v, m);
    end
    check(err_sticky == 1'b0, "R9 no error on good codes", 32'(err_sticky), 0);

    // R7: flush and code together; code held until ready
    @(negedge clk);
    flush = 1'b1;
    code_valid = 1'b1;
    code_data = {2'b00, 4'd1};
    #0.5;
    check(code_ready == 1'b0, "R7 ready low in flush", 32'(code_ready), 0);
    @(posedge clk);
    #1;
    cmp_out(1'b1, ref_cur, "R7 flush emits");
    @(negedge clk);
    flush = 1'b0;
    @(posedge clk);
    #1;
    code_valid = 1'b0;
    cmp_out(1'b0, '0, "R7 held code opens without emit");
    ref_open = 1'b1;
    ref_cur = '0;
    ref_cur[1] = 1'b1;

    // R9: misaligned and out-of-range group indexes
    send(2'b11, 2, "R9 misaligned");
    check(err_sticky == 1'b1, "R9 flag set", 32'(err_sticky), 1);
    send(2'b11, 12, "R9 beyond N");
    send(2'b10, 5, "R9 flip still works");
    ref_cur[5] = 1'b1;
    check(err_sticky == 1'b1, "R9 flag sticky", 32'(err_sticky), 1);
    send(2'b00, N, "R9 slice untouched by bad group");
    ref_cur = '0;
    do_flush("R7 flush open slice");
    do_flush("R7 flush empty emits nothing");
    @(negedge clk);
    check(slice_data == 10'h000, "R8 data held", 32'(slice_data), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule